// File: doc/BRIEF.md
# DRAM Clock-Enable Power-State Decoder

This block sits on the device side of a DRAM and decides, on every rising clock edge, what the clock-enable input means in the current power state. It keeps the clock-enable value from the previous edge and compares it with the value on the current edge. It combines that pair with the chip-select and command pins (row strobe, column strobe, write enable) and with a bank status input. From these it reports one action code and moves between a normal state, self refresh and power down.

When the device leaves a low-power state, a counter holds off ordinary commands for a programmable number of cycles. The count is set separately for each low-power mode. While the counter runs, only no-operation cycles are accepted. An illegal combination leaves the power state as it was and sets a sticky error flag, which stays set until the clear input is pulsed. When clock-enable is high on both edges and no exit hold-off is running, the command is passed to the normal command decoder, which lies outside this block.

Top module: `cke_power_fsm`

## Requirements
- R1: In self refresh, clock-enable low on both the previous and the current edge gives MAINTAIN (code 0), whatever the command pins carry, and the device stays in self refresh (state code 0).
- R2: In self refresh, a low-to-high clock-enable change with a quiet command gives EXIT (code 3). A quiet command means chip select high, or row strobe, column strobe and write enable all high. The device returns to the normal state, and `exit_busy` stays high for the next SRX_CYC edges.
- R3: In power down (state code 1), clock-enable low on both edges gives MAINTAIN. A low-to-high change with a quiet command gives EXIT, followed by PDX_CYC busy edges.
- R4: In either low-power state, a low-to-high clock-enable change with any non-quiet command gives ILLEGAL (code 5), and the state does not change.
- R5: In the normal state with `banks_idle` high and no hold-off running, a high-to-low clock-enable change with auto-refresh (chip select, row and column strobe low, write enable high) gives ENTER_SREF (code 1) and moves to self refresh.
- R6: In the normal state with no hold-off running, a high-to-low clock-enable change with a quiet command gives ENTER_PDN (code 2) and moves to power down. This holds whether `banks_idle` is high or low.
- R7: A high-to-low clock-enable change in the normal state gives ILLEGAL in two cases: auto-refresh while `banks_idle` is low, and any command that is neither quiet nor auto-refresh.
- R8: In the normal state with no hold-off running, clock-enable high on both edges gives PASS (code 4).
- R9: In the normal state, a previous clock-enable sample of low gives INVALID (code 6). In a low-power state, a previous sample of high gives INVALID. Neither case changes state or sets an error.
- R10: While `exit_busy` is high, clock-enable high with a quiet command gives MAINTAIN. Any other input while busy gives ILLEGAL.
- R11: `err_sticky` is set on the edge that reports ILLEGAL. It is cleared by `err_clr` only when no ILLEGAL is reported on the same edge.
- R12: After reset: `action` is MAINTAIN, `exit_busy` and `err_sticky` are low, the stored previous clock-enable is low, and `state` shows 2 (idle) when `banks_idle` is high or 3 (active) when it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock-enable sample on the current edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| banks_idle | input | 1 | High when every bank is precharged |
| err_clr | input | 1 | Clears the sticky error flag |
| action | output | 3 | Action decided on the last edge |
| state | output | 2 | 0 self refresh, 1 power down, 2 idle, 3 active |
| exit_busy | output | 1 | Exit hold-off running |
| err_sticky | output | 1 | An illegal combination has been seen |

## Verification
The bench covers five corner cases:

- **Command during a low-to-high transition out of a low-power state.** A design that treats any rising clock-enable as an exit would wake up on a read and report EXIT where ILLEGAL is expected.
- **Auto-refresh with banks open.** A design that skips the bank check would enter self refresh instead of flagging the command.
- **Commands during the exit hold-off.** An off-by-one in the counter shows up as PASS one edge early or one edge late. A counter loaded with the wrong mode's latency shows up as a busy window of the wrong length.
- **First edge after reset.** Because the previous clock-enable resets low, this edge must report INVALID. A design that resets that register high would report PASS.
- **Error clear on the same edge as a new ILLEGAL.** A design that gives the clear priority would drop the error.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

  typedef enum logic [1:0] {
    LP_NONE = 2'd0,
    LP_SREF = 2'd1,
    LP_PDN  = 2'd2
  } lp_e;

  typedef enum logic [2:0] {
    ACT_MAINTAIN   = 3'd0,
    ACT_ENTER_SREF = 3'd1,
    ACT_ENTER_PDN  = 3'd2,
    ACT_EXIT       = 3'd3,
    ACT_PASS       = 3'd4,
    ACT_ILLEGAL    = 3'd5,
    ACT_INVALID    = 3'd6
  } act_e;

  localparam logic [1:0] ST_SREF   = 2'd0;
  localparam logic [1:0] ST_PDN    = 2'd1;
  localparam logic [1:0] ST_IDLE   = 2'd2;
  localparam logic [1:0] ST_ACTIVE = 2'd3;

  // deselect, or a no-operation with the chip selected
  function automatic logic cmd_quiet(input logic cs_n, input logic ras_n,
                                     input logic cas_n, input logic we_n);
    return cs_n | (ras_n & cas_n & we_n);
  endfunction

  function automatic logic cmd_autoref(input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n);
    return ~cs_n & ~ras_n & ~cas_n & we_n;
  endfunction

  function automatic logic [1:0] state_code(input lp_e lp, input logic idle);
    case (lp)
      LP_SREF: return ST_SREF;
      LP_PDN:  return ST_PDN;
      default: return idle ? ST_IDLE : ST_ACTIVE;
    endcase
  endfunction

endpackage

// File: rtl/cke_edge_sampler.sv
module cke_edge_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  output logic cke_prev
);
  always_ff @(posedge clk) begin
    if (!rst_n) cke_prev <= 1'b0;
    else        cke_prev <= cke;
  end
endmodule

// File: rtl/cke_exit_timer.sv
module cke_exit_timer #(
  parameter int SRX_CYC = 8,
  parameter int PDX_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic from_sref,
  output logic busy
);
  localparam int MAXC = (SRX_CYC > PDX_CYC) ? SRX_CYC : PDX_CYC;
  localparam int CW   = (MAXC < 1) ? 1 : $clog2(MAXC + 1);
  localparam logic [CW-1:0] SRX_LD = CW'(SRX_CYC);
  localparam logic [CW-1:0] PDX_LD = CW'(PDX_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= from_sref ? SRX_LD : PDX_LD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/cke_action_decode.sv
module cke_action_decode
  import cke_pwr_pkg::*;
(
  input  lp_e  lp,
  input  logic cke_prev,
  input  logic cke,
  input  logic quiet,
  input  logic autoref,
  input  logic banks_idle,
  input  logic busy,
  output act_e act
);
  always_comb begin
    act = ACT_INVALID;
    if (lp != LP_NONE) begin
      if (cke_prev)      act = ACT_INVALID;
      else if (!cke)     act = ACT_MAINTAIN;
      else if (quiet)    act = ACT_EXIT;
      else               act = ACT_ILLEGAL;
    end else if (!cke_prev) begin
      act = ACT_INVALID;
    end else if (busy) begin
      act = (cke && quiet) ? ACT_MAINTAIN : ACT_ILLEGAL;
    end else if (cke) begin
      act = ACT_PASS;
    end else if (autoref) begin
      act = banks_idle ? ACT_ENTER_SREF : ACT_ILLEGAL;
    end else if (quiet) begin
      act = ACT_ENTER_PDN;
    end else begin
      act = ACT_ILLEGAL;
    end
  end
endmodule

// File: rtl/cke_power_fsm.sv
module cke_power_fsm
  import cke_pwr_pkg::*;
#(
  parameter int SRX_CYC = 8,
  parameter int PDX_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       banks_idle,
  input  logic       err_clr,
  output logic [2:0] action,
  output logic [1:0] state,
  output logic       exit_busy,
  output logic       err_sticky
);
  lp_e  lp_q, lp_d;
  act_e act_d, act_q;
  logic cke_prev;
  logic quiet, autoref;
  logic err_q;

  // named events for the checker
  logic ev_enter_sref, ev_enter_pdn, ev_exit, ev_illegal;

  assign quiet   = cmd_quiet(cs_n, ras_n, cas_n, we_n);
  assign autoref = cmd_autoref(cs_n, ras_n, cas_n, we_n);

  cke_edge_sampler u_smp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .cke_prev (cke_prev)
  );

  cke_action_decode u_dec (
    .lp         (lp_q),
    .cke_prev   (cke_prev),
    .cke        (cke),
    .quiet      (quiet),
    .autoref    (autoref),
    .banks_idle (banks_idle),
    .busy       (exit_busy),
    .act        (act_d)
  );

  assign ev_enter_sref = (act_d == ACT_ENTER_SREF);
  assign ev_enter_pdn  = (act_d == ACT_ENTER_PDN);
  assign ev_exit       = (act_d == ACT_EXIT);
  assign ev_illegal    = (act_d == ACT_ILLEGAL);

  cke_exit_timer #(
    .SRX_CYC (SRX_CYC),
    .PDX_CYC (PDX_CYC)
  ) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_exit),
    .from_sref (lp_q == LP_SREF),
    .busy      (exit_busy)
  );

  always_comb begin
    lp_d = lp_q;
    if (ev_enter_sref)     lp_d = LP_SREF;
    else if (ev_enter_pdn) lp_d = LP_PDN;
    else if (ev_exit)      lp_d = LP_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lp_q  <= LP_NONE;
      act_q <= ACT_MAINTAIN;
      err_q <= 1'b0;
    end else begin
      lp_q  <= lp_d;
      act_q <= act_d;
      if (ev_illegal)   err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  assign action     = act_q;
  assign state      = state_code(lp_q, banks_idle);
  assign err_sticky = err_q;
endmodule

// File: rtl/cke_power_chk.sv
module cke_power_chk
  import cke_pwr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic       cke_prev,
  input logic       banks_idle,
  input logic       exit_busy,
  input logic [2:0] action,
  input logic [1:0] lp,
  input logic       err_sticky
);
  AST_SREF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lp == LP_SREF && !cke_prev && !cke) |=> (lp == LP_SREF)); // R1

  AST_ILLEGAL_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (action == ACT_ILLEGAL) |-> (lp == $past(lp))); // R4

  AST_ILLEGAL_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (action == ACT_ILLEGAL) |-> err_sticky); // R11

  AST_SREF_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (action == ACT_ENTER_SREF) |-> ($past(banks_idle) && lp == LP_SREF)); // R5

  AST_NO_PASS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(exit_busy) |-> (action != ACT_PASS)); // R10

  AST_PASS_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (action == ACT_PASS) |-> ($past(cke_prev) && $past(cke))); // R8

  AST_EXIT_TO_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (action == ACT_EXIT) |-> (lp == LP_NONE && $past(lp) != LP_NONE)); // R2
endmodule

bind cke_power_fsm cke_power_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cke        (cke),
  .cke_prev   (cke_prev),
  .banks_idle (banks_idle),
  .exit_busy  (exit_busy),
  .action     (action),
  .lp         (lp_q),
  .err_sticky (err_sticky)
);

// File: tb/tb_cke_power_fsm.sv
module tb_cke_power_fsm;
  localparam int CLK_PERIOD = 10;
  localparam int SRX = 8;
  localparam int PDX = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic banks_idle = 1'b1, err_clr = 1'b0;
  logic [2:0] action;
  logic [1:0] state;
  logic exit_busy, err_sticky;

  int n_cmp = 0, n_bad = 0;

  // reference model: mode 0 normal, 1 self refresh, 2 power down
  int m_mode, m_prev, m_cnt, m_act, m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  cke_power_fsm #(.SRX_CYC(SRX), .PDX_CYC(PDX)) dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .banks_idle(banks_idle), .err_clr(err_clr),
    .action(action), .state(state), .exit_busy(exit_busy), .err_sticky(err_sticky)
  );

  function automatic int exp_state();
    if (m_mode == 1) return 0;
    if (m_mode == 2) return 1;
    return banks_idle ? 2 : 3;
  endfunction

  task automatic model_edge();
    bit nop, aref;
    int nxt;
    nop  = cs_n || (ras_n && cas_n && we_n);
    aref = !cs_n && !ras_n && !cas_n && we_n;
    nxt  = m_mode;
    if (m_mode != 0) begin
      if (m_prev == 1) m_act = 6;
      else if (!cke) m_act = 0;
      else if (nop) begin
        m_act = 3;
        m_cnt = (m_mode == 1) ? SRX + 1 : PDX + 1; // decremented below
        nxt = 0;
      end else m_act = 5;
    end else if (m_prev == 0) m_act = 6;
    else if (m_cnt > 0) m_act = (cke && nop) ? 0 : 5;
    else if (cke) m_act = 4;
    else if (aref) begin
      if (banks_idle) begin m_act = 1; nxt = 1; end
      else m_act = 5;
    end else if (nop) begin m_act = 2; nxt = 2; end
    else m_act = 5;
    if (m_cnt > 0) m_cnt--;
    if (m_act == 5) m_err = 1;
    else if (err_clr) m_err = 0;
    m_mode = nxt;
    m_prev = cke;
  endtask

  task automatic compare(input string req);
    n_cmp++;
    if (action !== 3'(m_act) || state !== 2'(exp_state()) ||
        exit_busy !== (m_cnt > 0) || err_sticky !== 1'(m_err)) begin
      n_bad++;
      $display("FAIL %s: act=%0d state=%0d busy=%0b err=%0b expected act=%0d state=%0d busy=%0b err=%0d",
               req, action, state, exit_busy, err_sticky, m_act, exp_state(), m_cnt > 0, m_err);
    end
  endtask

  task automatic cyc(input bit k, input bit [3:0] cmd, input string req);
    cke = k; {cs_n, ras_n, cas_n, we_n} = cmd;
    @(posedge clk);
    model_edge();
    #1 compare(req);
  endtask

  localparam bit [3:0] C_NOP  = 4'b0111;
  localparam bit [3:0] C_DES  = 4'b1000;
  localparam bit [3:0] C_READ = 4'b0101;
  localparam bit [3:0] C_WR   = 4'b0100;
  localparam bit [3:0] C_AREF = 4'b0001;

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: act=%0d expected run to end", action);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    m_mode = 0; m_prev = 0; m_cnt = 0; m_act = 0; m_err = 0;
    compare("R12");
    rst_n = 1'b1;
    cyc(1, C_NOP, "R9");              // previous sample low after reset
    cyc(1, C_READ, "R8");
    cyc(1, C_WR, "R8");
    // power down from idle
    cyc(0, C_NOP, "R6");
    cyc(0, C_READ, "R3");
    cyc(0, C_AREF, "R3");
    cyc(1, C_READ, "R4");             // illegal wake, stays down
    cyc(0, C_NOP, "R3");
    cyc(1, C_NOP, "R3");              // exit
    cyc(1, C_NOP, "R10");
    cyc(1, C_READ, "R10");            // illegal while busy
    cyc(1, C_NOP, "R10");
    cyc(1, C_READ, "R8");
    // clear vs set priority
    err_clr = 1'b1;
    cyc(0, C_WR, "R11");              // ILLEGAL wins over clear
    cyc(1, C_NOP, "R11");             // prev low in normal -> invalid, clear applies
    err_clr = 1'b0;
    // self refresh
    cyc(1, C_NOP, "R8");
    cyc(0, C_AREF, "R5");
    cyc(0, C_READ, "R1");
    cyc(0, C_WR, "R1");
    cyc(1, C_WR, "R4");
    cyc(0, C_DES, "R1");
    cyc(1, C_DES, "R2");
    for (int i = 0; i < SRX; i++) cyc(1, C_NOP, "R2");
    cyc(1, C_READ, "R2");
    // banks active
    banks_idle = 1'b0;
    cyc(1, C_READ, "R12");
    cyc(0, C_AREF, "R7");
    cyc(1, C_NOP, "R9");
    cyc(1, C_NOP, "R8");
    cyc(0, C_WR, "R7");
    cyc(1, C_NOP, "R9");
    cyc(1, C_NOP, "R8");
    cyc(0, C_DES, "R6");
    cyc(1, C_NOP, "R3");
    cyc(0, C_NOP, "R10");             // falling during hold-off
    // mixed stream
    for (int i = 0; i < 600; i++) begin
      bit [3:0] c;
      c = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 2) == 0) c = C_NOP;
      banks_idle = 1'($urandom_range(0, 1));
      err_clr = ($urandom_range(0, 7) == 0);
      cyc(1'($urandom_range(0, 1)), c, "R4");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule